// File: doc/BRIEF.md
# Level-Qualified Interrupt Deglitcher

This block sits between a noisy device interrupt line and an interrupt controller. An upstream edge detector sends a one-clock strobe on every transition of the line, both rising and falling. The device, however, asks for service by holding the line high, so an event from a falling edge is spurious. The block decides which events are real before anything is forwarded.

On each accepted strobe the block brings the raw line through a two-stage synchroniser. It then takes pairs of samples of the line, one clock apart, and compares the two samples of each pair. A pair that disagrees starts another attempt, up to a parameterised limit (eight by default). When a pair agrees and both samples are high, the block emits a qualified interrupt pulse one clock wide. When a pair agrees low, or every attempt ends in disagreement, the event is dropped and nothing is emitted. A busy output marks the qualification window. All pins are plain control signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `lvl_irq_qualifier`

## Requirements
- R1: While rst_n is low, and on the first clock after it is released, irq_out and busy are 0.
- R2: The line level used by a sample taken at clock edge t is the level pin_raw had just before edge t-2, because of the two synchroniser flops.
- R3: An edge_evt seen high at edge E while busy is 0 makes busy 1 from edge E. Attempt j (counting from 0) compares the samples taken at edges E+1+2j and E+2+2j.
- R4: When an attempt's two samples are both 1, irq_out is 1 for exactly one clock, starting at the second sample's edge. busy falls at that same edge.
- R5: When an attempt's two samples are both 0, the event is dropped. irq_out stays 0 and busy falls at the second sample's edge.
- R6: When the samples of attempt j differ, attempt j+1 follows at once. After MAX_TRIES (default 8) disagreeing attempts, the event is dropped with no pulse and busy falls at edge E+2*MAX_TRIES.
- R7: An edge_evt that arrives while busy is 1 is ignored. It neither restarts the attempts nor adds a pulse.
- R8: Without an accepted edge_evt, irq_out stays 0 whatever pin_raw does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronised device interrupt line |
| edge_evt | input | 1 | One-clock strobe from the both-edge detector |
| irq_out | output | 1 | Qualified interrupt, one clock wide |
| busy | output | 1 | High while an event is being qualified |

## Verification
The hardest case to reach is a match on the very last attempt, set against exhaustion just one clock later. Two input patterns separate them. In the first, the line toggles every clock for thirteen cycles after the event and then settles high, so only the eighth pair agrees. In the second, the line toggles for fourteen cycles, so the eighth pair still straddles a transition. The bench drives pin_raw on falling clock edges in a known phase to the event strobe, so each pair's contents are fixed by the two-flop delay. It also repeats the strobe during a qualification to show that the strobe is ignored while busy.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
  typedef enum logic [1:0] {
    Q_IDLE   = 2'd0,
    Q_FIRST  = 2'd1,
    Q_SECOND = 2'd2
  } qstate_t;
endpackage

// File: rtl/irqq_sync.sv
module irqq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d_in;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];

  // R2: the output repeats the input from STAGES edges earlier (checked here for the last stage)
  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q_out == $past(chain[(STAGES > 1) ? STAGES-2 : 0])));
endmodule

// File: rtl/irqq_try_cnt.sv
module irqq_try_cnt #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_try
);
  localparam int CW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_TRIES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign last_try = (cnt == LAST);

  // R6: the attempt count never passes its limit
  p_tries_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R6: a clear always restarts counting from the first attempt
  p_clear_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/irqq_fsm.sv
module irqq_fsm
  import irqq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic evt,
  input  logic last_try,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic irq_q,
  output logic busy
);
  qstate_t st;
  logic    first_smp;
  logic    pair_match;

  assign pair_match = (smp == first_smp);
  assign cnt_clr    = (st == Q_IDLE);
  assign cnt_inc    = (st == Q_SECOND) && !pair_match;
  assign busy       = (st != Q_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= Q_IDLE;
      first_smp <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st)
        Q_IDLE:   if (evt) st <= Q_FIRST;
        Q_FIRST: begin
          first_smp <= smp;
          st        <= Q_SECOND;
        end
        Q_SECOND: begin
          if (pair_match) begin
            irq_q <= smp;
            st    <= Q_IDLE;
          end else if (last_try) begin
            st <= Q_IDLE;
          end else begin
            st <= Q_FIRST;
          end
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

  // R3: an event taken while idle opens the qualification window
  p_evt_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && evt) |=> busy);
  // R4: the qualified pulse lasts one clock
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R4: the window closes together with the pulse
  p_pulse_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !busy);
  // R5: a low agreeing pair never yields a pulse
  p_low_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == Q_SECOND && pair_match && !smp) |=> (!irq_q && !busy));
  // R7: an event while busy does not move the state out of its sequence
  p_busy_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == Q_FIRST) |=> (st == Q_SECOND));
  // R8: no pulse can follow an idle clock
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !irq_q);
endmodule

// File: rtl/lvl_irq_qualifier.sv
module lvl_irq_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_TRIES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic edge_evt,
  output logic irq_out,
  output logic busy
);
  logic smp;
  logic cnt_clr;
  logic cnt_inc;
  logic last_try;

  irqq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_raw),
    .q_out (smp)
  );

  irqq_try_cnt #(.MAX_TRIES(MAX_TRIES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .last_try (last_try)
  );

  irqq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (smp),
    .evt      (edge_evt),
    .last_try (last_try),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .irq_q    (irq_out),
    .busy     (busy)
  );

  // R1: outputs are quiet on the first clock out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!irq_out && !busy));
endmodule

// File: tb/lvl_irq_qualifier_bench.sv
module lvl_irq_qualifier_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_raw = 1'b0;
  logic edge_evt = 1'b0;
  logic irq_out;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lvl_irq_qualifier u_lvl_irq_qualifier (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .edge_evt(edge_evt),
    .irq_out(irq_out), .busy(busy)
  );

  // fields: [17] prior level, [16:12] toggle cycles T, [11] final level,
  // [10] repeat event while busy, [9:5] expected pulse offset (0 = none),
  // [4:0] offset at which busy falls
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 5'd0,  1'b1, 1'b0, 5'd2,  5'd2 },  // R4 first pair high
    {1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  5'd2 },  // R5 first pair low
    {1'b0, 5'd0,  1'b1, 1'b0, 5'd4,  5'd4 },  // R2 R6 rising just before event
    {1'b0, 5'd13, 1'b1, 1'b0, 5'd16, 5'd16},  // R6 match on last attempt
    {1'b0, 5'd14, 1'b1, 1'b0, 5'd0,  5'd16},  // R6 exhausted by one clock
    {1'b0, 5'd5,  1'b1, 1'b0, 5'd8,  5'd8 },  // R6 settles mid-way
    {1'b0, 5'd30, 1'b1, 1'b0, 5'd0,  5'd16},  // R6 never settles
    {1'b1, 5'd0,  1'b1, 1'b1, 5'd2,  5'd2 },  // R7 repeated event ignored
    {1'b0, 5'd3,  1'b0, 1'b0, 5'd0,  5'd6 }   // R5 settles low after retries
  };

  function automatic logic pval(logic prior, int t, logic fin, int k);
    if (k < 0) return prior;
    if (k < t) return (k % 2 == 0);
    return fin;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(irq_out == 1'b0 && busy == 1'b0, "R1 in reset", {irq_out, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_out == 1'b0 && busy == 1'b0, "R1 after release", {irq_out, busy}, 0);

    // table walk: R2..R7
    for (int v = 0; v < NV; v++) begin
      logic prior, fin, dup;
      int t, pm, em, npulse, ppos, busy_prev, busy_end;
      prior = VEC[v][17];
      t     = int'(VEC[v][16:12]);
      fin   = VEC[v][11];
      dup   = VEC[v][10];
      pm    = int'(VEC[v][9:5]);
      em    = int'(VEC[v][4:0]);
      pin_raw = prior;
      repeat (4) @(negedge clk);
      pin_raw  = pval(prior, t, fin, 0);
      edge_evt = 1'b1;
      npulse = 0; ppos = -1; busy_prev = 1; busy_end = -1;
      for (int m = 0; m < 20; m++) begin
        @(negedge clk);
        if (irq_out) begin npulse++; ppos = m; end
        if (busy_end < 0 && !busy) busy_end = m;
        edge_evt = (dup && m <= 1);
        pin_raw  = pval(prior, t, fin, m + 1);
      end
      if (pm != 0)
        check(npulse == 1 && ppos == pm, $sformatf("R4 vec%0d pulse offset", v), ppos, pm);
      else
        check(npulse == 0, $sformatf("R5 R6 vec%0d dropped pulses", v), npulse, 0);
      check(busy_end == em, $sformatf("R3 R6 R7 vec%0d busy end", v), busy_end, em);
    end

    // R8: line activity without an event gives nothing
    begin
      int np;
      np = 0;
      for (int m = 0; m < 24; m++) begin
        @(negedge clk);
        pin_raw = (m % 3 != 0);
        if (irq_out || busy) np++;
      end
      check(np == 0, "R8 no event no pulse", np, 0);
    end

    // R1: reset in the middle of a qualification clears it
    begin
      int np;
      pin_raw = 1'b1;
      repeat (4) @(negedge clk);
      edge_evt = 1'b1;
      @(negedge clk);
      edge_evt = 1'b0;
      check(busy == 1'b1, "R3 busy after event", busy, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(irq_out == 1'b0 && busy == 1'b0, "R1 mid-run reset", {irq_out, busy}, 0);
      rst_n = 1'b1;
      np = 0;
      for (int m = 0; m < 20; m++) begin
        @(negedge clk);
        if (irq_out) np++;
      end
      check(np == 0, "R1 R8 no pulse after reset", np, 0);
    end

    // R2: line rises on the event edge itself; the stale low is sampled first
    begin
      int ppos;
      pin_raw = 1'b0;
      repeat (4) @(negedge clk);
      pin_raw  = 1'b1;
      edge_evt = 1'b1;
      ppos = -1;
      for (int m = 0; m < 12; m++) begin
        @(negedge clk);
        edge_evt = 1'b0;
        if (irq_out && ppos < 0) ppos = m;
      end
      check(ppos == 4, "R2 two-flop delay", ppos, 4);
    end

    done = 1'b1;
    finish_run();
  end
endmodule